// File: doc/BRIEF.md
# Parallel Port Byte Receiver

This block is the peripheral end of a compatibility-mode parallel printer port. It watches the host's active-low strobe. Once a strobe has stayed low long enough to count as valid, the block latches the eight data lines and raises `busy` on the next clock. It then places the byte into a small receive FIFO. When the byte is stored, it sends an active-low acknowledge pulse of a set length and releases `busy` at the end of that pulse, so the host may send the next byte.

The FIFO drains through a valid/ready output stream. `m_valid` stays high while a byte is waiting, and `m_data` shows the oldest byte. A byte leaves on a clock edge where `m_valid` and `m_ready` are both high. While `m_ready` is low, `m_valid` and `m_data` hold their values. When the FIFO is full, the block applies back-pressure to the host: `busy` stays high and no acknowledge is sent until a slot frees.

The host's active-low initialise line is honoured only when `init_en` is high. While it is honoured, the handshake returns to idle, the FIFO is flushed and `busy` is held high. The paper-out, select and fault status outputs are registered copies of local inputs. The fault output is active-low.

Top module: `par_rx_port`

## Requirements
- R1: After reset, `busy` is 0, `ack_n` is 1, `m_valid` is 0, and `fault_n` is 1 until the first status sample.
- R2: A strobe that is low for at least STB_MIN synchronised clocks captures `pdata` as one byte. A strobe that is low for a single clock captures nothing and leaves `busy` at 0.
- R3: `busy` goes to 1 on the clock after a valid strobe is recognised and stays at 1 until the acknowledge pulse ends. It is at 1 within 5 clocks of the strobe falling.
- R4: After the byte is written into the FIFO, `ack_n` is 0 for exactly ACK_CLKS clocks. `busy` is 0 on the clock on which `ack_n` returns to 1.
- R5: With the FIFO full (DEPTH bytes held), a new byte keeps `busy` at 1 and `ack_n` at 1. Once one byte is read out, the held byte is stored and the handshake completes. The FIFO never holds more than DEPTH bytes.
- R6: Bytes leave through `m_valid`/`m_ready` in arrival order. While `m_valid` is 1 and `m_ready` is 0, `m_valid` and `m_data` do not change.
- R7: With `init_en`=1, `init_n`=0 flushes the FIFO (so `m_valid` is 0), returns the handshake to idle and holds `busy` at 1 until `init_n` returns to 1.
- R8: With `init_en`=0, `init_n` has no effect: stored bytes remain and `busy` stays 0.
- R9: `pe` and `sel` equal `paper_out_i` and `select_i` one clock later. `fault_n` equals the inverse of `fault_i` one clock later.
- R10: A strobe held low after its byte is acknowledged yields no second byte. The next byte requires the strobe to return high first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stb_n | input | 1 | Host strobe, active-low, asynchronous |
| pdata | input | 8 | Host data lines |
| init_n | input | 1 | Host initialise request, active-low, asynchronous |
| init_en | input | 1 | 1 = honour `init_n` |
| busy | output | 1 | Busy to host |
| ack_n | output | 1 | Acknowledge pulse to host, active-low |
| paper_out_i | input | 1 | Local paper-out status |
| select_i | input | 1 | Local selected status |
| fault_i | input | 1 | Local fault status, active-high |
| pe | output | 1 | Paper-out to host |
| sel | output | 1 | Select to host |
| fault_n | output | 1 | Fault to host, active-low |
| m_valid | output | 1 | Received byte available |
| m_data | output | 8 | Oldest received byte |
| m_ready | input | 1 | Consumer accepts byte |

## Verification
The hardest state to reach is a strobe that arrives while the FIFO is full. The handshake then has to stay parked in its store phase with `busy` high and no acknowledge. The bench reaches this by holding `m_ready` low, sending enough bytes to fill every slot, and strobing once more. It then watches `busy` and `ack_n` for a long window before re-enabling the reader, so that the held byte must enter the FIFO and acknowledge in order. Initialise is applied only after acknowledges have completed, with bytes still stored, so that the flush can be seen at `m_valid`.

// File: rtl/par_rx_pkg.sv
package par_rx_pkg;
  typedef enum logic [1:0] {
    HS_IDLE  = 2'd0,
    HS_STORE = 2'd1,
    HS_ACK   = 2'd2
  } hs_state_t;
endpackage

// File: rtl/par_rx_sync.sv
module par_rx_sync #(
  parameter int W = 1,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/par_rx_stb_filt.sv
module par_rx_stb_filt #(
  parameter int STB_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_s,
  input  logic clear,
  output logic stb_evt
);
  localparam int CW = $clog2(STB_MIN + 1);
  localparam logic [CW-1:0] LAST = CW'(STB_MIN - 1);

  logic [CW-1:0] low_cnt;
  logic          armed;

  assign stb_evt = armed && !stb_s && (low_cnt == LAST) && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      armed   <= 1'b0;
    end else if (clear) begin
      low_cnt <= '0;
      armed   <= 1'b0;
    end else if (stb_s) begin
      low_cnt <= '0;
      armed   <= 1'b1;
    end else begin
      if (low_cnt != LAST) low_cnt <= low_cnt + 1'b1;
      if (stb_evt) armed <= 1'b0;
    end
  end

  p_one_shot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stb_evt |=> !stb_evt);
endmodule

// File: rtl/par_rx_fifo.sv
module par_rx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          rd_ready
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic [AW:0]   fill;
  logic          do_wr, do_rd;

  assign fill     = wp - rp;
  assign wr_ready = (fill != (AW+1)'(DEPTH));
  assign rd_valid = (fill != '0);
  assign rd_data  = mem[rp[AW-1:0]];
  assign do_wr    = wr_valid && wr_ready && !flush;
  assign do_rd    = rd_valid && rd_ready && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_wr) wp <= wp + 1'b1;
      if (do_rd) rp <= rp + 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_wr && (wp[AW-1:0] == AW'(i))) mem[i] <= wr_data;
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH));
  p_hold_out_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !flush) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: rtl/par_rx_hs.sv
module par_rx_hs
  import par_rx_pkg::*;
#(
  parameter int DW       = 8,
  parameter int ACK_CLKS = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_evt,
  input  logic [DW-1:0] pdata,
  input  logic          init_act,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data,
  input  logic          wr_ready,
  output logic          busy,
  output logic          ack_n
);
  localparam int CW = $clog2(ACK_CLKS + 1);
  localparam logic [CW-1:0] ACK_LOAD = CW'(ACK_CLKS - 1);

  hs_state_t     state;
  logic [CW-1:0] ack_cnt;
  logic [DW-1:0] byte_q;

  assign wr_valid = (state == HS_STORE) && !init_act;
  assign wr_data  = byte_q;
  assign busy     = (state != HS_IDLE) || init_act;
  assign ack_n    = (state != HS_ACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= HS_IDLE;
      ack_cnt <= '0;
      byte_q  <= '0;
    end else if (init_act) begin
      state   <= HS_IDLE;
      ack_cnt <= '0;
    end else begin
      unique case (state)
        HS_IDLE: if (stb_evt) begin
          byte_q <= pdata;
          state  <= HS_STORE;
        end
        HS_STORE: if (wr_ready) begin
          ack_cnt <= ACK_LOAD;
          state   <= HS_ACK;
        end
        HS_ACK: begin
          if (ack_cnt == '0) state <= HS_IDLE;
          else ack_cnt <= ack_cnt - 1'b1;
        end
        default: state <= HS_IDLE;
      endcase
    end
  end

  p_busy_on_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_evt && state == HS_IDLE) |=> busy);
  p_ack_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> busy);
  p_full_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == HS_STORE && !wr_ready && !init_act) |=> (busy && ack_n));
  p_init_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_act |=> (state == HS_IDLE));
  p_init_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    init_act |-> busy);
endmodule

// File: rtl/par_rx_port.sv
module par_rx_port #(
  parameter int DW       = 8,
  parameter int DEPTH    = 4,
  parameter int ACK_CLKS = 1000,
  parameter int STB_MIN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stb_n,
  input  logic [DW-1:0] pdata,
  input  logic          init_n,
  input  logic          init_en,
  output logic          busy,
  output logic          ack_n,
  input  logic          paper_out_i,
  input  logic          select_i,
  input  logic          fault_i,
  output logic          pe,
  output logic          sel,
  output logic          fault_n,
  output logic          m_valid,
  output logic [DW-1:0] m_data,
  input  logic          m_ready
);
  logic [1:0]    ctl_s;
  logic          init_act, stb_evt;
  logic          wr_valid, wr_ready;
  logic [DW-1:0] wr_data;

  par_rx_sync #(.W(2), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({init_n, stb_n}), .q(ctl_s)
  );

  assign init_act = init_en && !ctl_s[1];

  par_rx_stb_filt #(.STB_MIN(STB_MIN)) u_filt (
    .clk(clk), .rst_n(rst_n), .stb_s(ctl_s[0]), .clear(init_act),
    .stb_evt(stb_evt)
  );

  par_rx_hs #(.DW(DW), .ACK_CLKS(ACK_CLKS)) u_hs (
    .clk(clk), .rst_n(rst_n), .stb_evt(stb_evt), .pdata(pdata),
    .init_act(init_act), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .busy(busy), .ack_n(ack_n)
  );

  par_rx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(init_act),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(m_valid), .rd_data(m_data), .rd_ready(m_ready)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe      <= 1'b0;
      sel     <= 1'b0;
      fault_n <= 1'b1;
    end else begin
      pe      <= paper_out_i;
      sel     <= select_i;
      fault_n <= !fault_i;
    end
  end

  p_fault_inv_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fault_n == !$past(fault_i)));
  p_sel_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sel == $past(select_i)));
endmodule

// File: tb/par_rx_port_test.sv
module par_rx_port_test;
  localparam int ACK = 8;
  localparam int DEP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb_n = 1'b1, init_n = 1'b1, init_en = 1'b1, m_ready = 1'b1;
  logic [7:0] pdata = '0;
  logic paper_out_i = 1'b0, select_i = 1'b0, fault_i = 1'b0;
  logic busy, ack_n, pe, sel, fault_n, m_valid;
  logic [7:0] m_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] expq[$];

  always #2.5 clk = ~clk;

  par_rx_port #(.DW(8), .DEPTH(DEP), .ACK_CLKS(ACK), .STB_MIN(2)) uut (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .pdata(pdata),
    .init_n(init_n), .init_en(init_en), .busy(busy), .ack_n(ack_n),
    .paper_out_i(paper_out_i), .select_i(select_i), .fault_i(fault_i),
    .pe(pe), .sel(sel), .fault_n(fault_n),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] b);
    while (busy) tick(1);
    pdata = b;
    stb_n = 1'b0;
    expq.push_back(b);
    tick(5);
    chk(busy == 1'b1, "R3 busy after strobe", busy, 1);
    stb_n = 1'b1;
    tick(1);
  endtask

  // monitor: scoreboard, ack width, output hold
  int ack_w = 0;
  bit prev_ack_low = 0;
  bit prev_stall = 0;
  logic [7:0] prev_data;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_stall) begin
        chk(m_valid && m_data == prev_data, "R6 hold while stalled", m_data, prev_data);
      end
      prev_stall = m_valid && !m_ready && !(init_en && !init_n);
      prev_data  = m_data;
      if (m_valid && m_ready) begin
        if (expq.size() == 0) chk(0, "R6 unexpected byte", m_data, -1);
        else begin
          logic [7:0] e;
          e = expq.pop_front();
          chk(m_data == e, "R2/R6 byte order", m_data, e);
        end
      end
      if (!ack_n) ack_w++;
      else if (prev_ack_low) begin
        chk(ack_w == ACK, "R4 ack width", ack_w, ACK);
        chk(busy == 1'b0, "R4 busy drops with ack", busy, 0);
        ack_w = 0;
      end
      prev_ack_low = !ack_n;
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end

  initial begin
    tick(3);
    chk(busy == 0, "R1 reset busy", busy, 0);
    chk(ack_n == 1, "R1 reset ack_n", ack_n, 1);
    chk(m_valid == 0, "R1 reset m_valid", m_valid, 0);
    chk(fault_n == 1, "R1 reset fault_n", fault_n, 1);
    rst_n = 1'b1;
    tick(3);

    // R9 status pass-through
    paper_out_i = 1; select_i = 1; fault_i = 1;
    tick(1);
    chk(pe == 1 && sel == 1, "R9 pe/sel", {pe, sel}, 3);
    chk(fault_n == 0, "R9 fault_n inverted", fault_n, 0);
    fault_i = 0; select_i = 0;
    tick(1);
    chk(fault_n == 1 && sel == 0, "R9 fault clear", {fault_n, sel}, 2);

    // R2 basic bytes and one-clock glitch
    send_byte(8'hA5);
    send_byte(8'h3C);
    while (busy || expq.size() != 0) tick(1);
    stb_n = 1'b0; pdata = 8'hEE;
    tick(1);
    stb_n = 1'b1;
    tick(10);
    chk(busy == 0, "R2 glitch ignored busy", busy, 0);
    chk(m_valid == 0, "R2 glitch no byte", m_valid, 0);

    // R10 strobe held low
    pdata = 8'h71; stb_n = 1'b0; expq.push_back(8'h71);
    tick(40);
    chk(busy == 0, "R10 no retrigger while low", busy, 0);
    chk(expq.size() == 0, "R10 single byte", expq.size(), 0);
    stb_n = 1'b1;
    tick(4);
    send_byte(8'h72);
    while (busy || expq.size() != 0) tick(1);

    // R5 full FIFO back-pressure
    m_ready = 0;
    for (int i = 0; i < DEP; i++) send_byte(8'h10 + 8'(i));
    send_byte(8'h99);
    for (int i = 0; i < 20; i++) begin
      chk(busy == 1 && ack_n == 1, "R5 parked while full", {busy, ack_n}, 3);
      tick(1);
    end
    m_ready = 1;
    while (busy || expq.size() != 0) tick(1);
    chk(m_valid == 0, "R5 drained", m_valid, 0);

    // R8 init disabled
    init_en = 0; m_ready = 0;
    send_byte(8'h5A);
    while (busy) tick(1);
    init_n = 0;
    tick(10);
    chk(m_valid == 1 && m_data == 8'h5A, "R8 init ignored data", m_data, 8'h5A);
    chk(busy == 0, "R8 init ignored busy", busy, 0);
    init_n = 1;
    tick(3);
    m_ready = 1;
    while (expq.size() != 0) tick(1);

    // R7 init enabled flushes
    init_en = 1; m_ready = 0;
    send_byte(8'hC1);
    send_byte(8'hC2);
    while (busy) tick(1);
    init_n = 0;
    tick(4);
    chk(m_valid == 0, "R7 flush", m_valid, 0);
    chk(busy == 1, "R7 busy in init", busy, 1);
    expq.delete();
    tick(10);
    chk(busy == 1, "R7 busy held", busy, 1);
    init_n = 1;
    tick(4);
    chk(busy == 0, "R7 busy released", busy, 0);
    m_ready = 1;
    send_byte(8'hD4);
    while (busy || expq.size() != 0) tick(1);
    chk(expq.size() == 0, "R7 post-init byte", expq.size(), 0);

    tick(5);
    finish_run();
  end
endmodule